// File: doc/BRIEF.md
# Thread Cluster Memory Request Prioritizer

This block produces a priority level for every hardware thread that shares a memory scheduler. Over a fixed quantum of cycles it tallies, per thread, the requests issued, the row-buffer hits among them and a running sum of how many banks the thread keeps busy. When the quantum ends it splits the threads into a light cluster and a heavy cluster based on the request tallies and a programmable threshold fraction. It then publishes a level vector that the request arbiter uses directly.

Light threads always outrank heavy threads. Inside the light cluster the thread that asked for less memory wins. Inside the heavy cluster the order is rotated every shuffle interval with an uneven shuffle: each heavy thread gets a niceness score at the quantum boundary. Threads with a high score spend more shuffle steps near the top. Quantum and shuffle lengths are parameters, so short values can be used for test.

Top module: `tcp_prio`

## Requirements
- R1: After reset, every thread is in the light cluster and thread t holds level NTHR-1-t.
- R2: A quantum is exactly QLEN cycles of input. The new clustering is visible on `rank_o` from the clock edge that ends the quantum. Between quantum ends, the cluster split does not change.
- R3: Threads are sorted by ascending request count, with ties going to the lower thread ID. A thread is light when the request sum of all threads up to and including it in that order, times 256, is at most `thr_i` times the total request count. A total of zero makes every thread light.
- R4: Every light thread holds a level of at least H, and every heavy thread holds a level below H, where H is the number of heavy threads.
- R5: A light thread whose position in the ascending order among light threads is j holds level NTHR-1-j.
- R6: The niceness of a thread is its bank-parallelism rank minus its row-hit rank. Each rank is the number of threads with a strictly smaller accumulated value. A hit is counted only in a cycle where the thread also issues a request. The bank sum adds `blp_i` only in request cycles.
- R7: Heavy threads are ordered by descending niceness, with ties going to the lower ID, giving positions p = 0..H-1. At shuffle step s, position s takes level H-1. A position p<s takes level H-2-p, and a position p>s takes level H-1-p.
- R8: The shuffle step starts at 0 at each quantum end. It advances by one every SLEN cycles and wraps to 0 after H-1. It stays 0 while H is at most 1.
- R9: The levels on `rank_o` are always a permutation of 0..NTHR-1.
- R10: The level of thread t sits in `rank_o[t*RW +: RW]`, with RW = clog2(NTHR). A larger level means the thread is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_v | input | NTHR | Thread t issues a memory request this cycle |
| hit_v | input | NTHR | The request of thread t this cycle hit an open row |
| blp_i | input | NTHR*BLPW | Per-thread count of banks holding its outstanding requests |
| thr_i | input | 8 | Light-cluster threshold, a fraction of total requests in 1/256 units |
| rank_o | output | NTHR*RW | Per-thread priority level |

## Verification
The bench targets the quantum edge, where a design that is off by one cycle would either lose the last cycle's requests or publish the decision one edge late. It also targets the threshold equality case, equal request counts and an all-idle quantum. Mistakes in tie-breaking there would swap two threads or misplace the split. Shuffle steps are sampled at each interval while the heavy cluster has zero, one, two and four members. A wrong wrap, a missing restart at the quantum end, or a symmetric rotation would show the wrong thread on top. A niceness case is also built in which the thread with many hits and few busy banks must rank below its partner at step 0.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
    // threshold fraction resolution in bits (units of 1/256)
    localparam int FRAC_W = 8;
endpackage

// File: rtl/tcp_mon.sv
module tcp_mon #(
    parameter int NTHR = 4,
    parameter int CW   = 20,
    parameter int BLPW = 3,
    parameter int AW   = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NTHR-1:0]      req_v,
    input  logic [NTHR-1:0]      hit_v,
    input  logic [NTHR*BLPW-1:0] blp_i,
    output logic [NTHR*CW-1:0]   req_acc,
    output logic [NTHR*CW-1:0]   hit_acc,
    output logic [NTHR*AW-1:0]   blp_acc
);
    // per-thread accumulators; outputs include the current cycle's sample
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        typedef struct packed {
            logic [CW-1:0] req;
            logic [CW-1:0] hit;
            logic [AW-1:0] blp;
        } acc_t;

        acc_t acc_d, acc_q;

        always_comb begin
            acc_d     = acc_q;
            acc_d.req = acc_q.req + CW'(req_v[t]);
            acc_d.hit = acc_q.hit + CW'(req_v[t] & hit_v[t]);
            acc_d.blp = acc_q.blp + (req_v[t] ? AW'(blp_i[t*BLPW +: BLPW]) : AW'(0));
        end

        assign req_acc[t*CW +: CW] = acc_d.req;
        assign hit_acc[t*CW +: CW] = acc_d.hit;
        assign blp_acc[t*AW +: AW] = acc_d.blp;

        always_ff @(posedge clk) begin
            if (!rst_n || clr) acc_q <= '0;
            else               acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/tcp_clu.sv
module tcp_clu
    import tcp_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int CW   = 20,
    parameter int AW   = 23,
    parameter int RW   = 2,
    parameter int HW   = 3
) (
    input  logic [NTHR*CW-1:0] req_acc,
    input  logic [NTHR*CW-1:0] hit_acc,
    input  logic [NTHR*AW-1:0] blp_acc,
    input  logic [FRAC_W-1:0]  thr_i,
    output logic [NTHR-1:0]    light_o,
    output logic [NTHR*RW-1:0] lidx_o,
    output logic [NTHR*RW-1:0] hidx_o,
    output logic [HW-1:0]      hcnt_o
);
    localparam int SW = CW + $clog2(NTHR) + 1;
    localparam int PW = SW + FRAC_W;

    logic [CW-1:0] rq [NTHR];
    logic [CW-1:0] hc [NTHR];
    logic [AW-1:0] bp [NTHR];

    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            rq[t] = req_acc[t*CW +: CW];
            hc[t] = hit_acc[t*CW +: CW];
            bp[t] = blp_acc[t*AW +: AW];
        end
    end

    // cluster split by prefix sum over ascending request order
    logic [SW-1:0]   total;
    logic [SW-1:0]   pre [NTHR];
    logic [NTHR-1:0] lt;

    always_comb begin
        total = '0;
        for (int t = 0; t < NTHR; t++) total = total + SW'(rq[t]);
        for (int t = 0; t < NTHR; t++) begin
            pre[t] = '0;
            for (int j = 0; j < NTHR; j++) begin
                if (rq[j] < rq[t] || (rq[j] == rq[t] && j <= t))
                    pre[t] = pre[t] + SW'(rq[j]);
            end
            lt[t] = {pre[t], {FRAC_W{1'b0}}} <= (PW'(thr_i) * PW'(total));
        end
    end

    // niceness = bank-parallelism rank minus row-hit rank
    int nice [NTHR];

    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            int br;
            int hr;
            br = 0;
            hr = 0;
            for (int j = 0; j < NTHR; j++) begin
                if (bp[j] < bp[t]) br++;
                if (hc[j] < hc[t]) hr++;
            end
            nice[t] = br - hr;
        end
    end

    // positions inside each cluster
    always_comb begin
        int nh;
        nh = 0;
        for (int t = 0; t < NTHR; t++) begin
            int nl;
            int np;
            nl = 0;
            np = 0;
            for (int j = 0; j < NTHR; j++) begin
                if (j != t && lt[j] && (rq[j] < rq[t] || (rq[j] == rq[t] && j < t)))
                    nl++;
                if (j != t && !lt[j] && (nice[j] > nice[t] || (nice[j] == nice[t] && j < t)))
                    np++;
            end
            lidx_o[t*RW +: RW] = lt[t] ? RW'(nl) : RW'(0);
            hidx_o[t*RW +: RW] = lt[t] ? RW'(0) : RW'(np);
            if (!lt[t]) nh++;
        end
        hcnt_o  = HW'(nh);
        light_o = lt;
    end
endmodule

// File: rtl/tcp_rank.sv
module tcp_rank #(
    parameter int NTHR = 4,
    parameter int RW   = 2,
    parameter int HW   = 3
) (
    input  logic [NTHR-1:0]    light,
    input  logic [NTHR*RW-1:0] lidx,
    input  logic [NTHR*RW-1:0] hidx,
    input  logic [HW-1:0]      hcnt,
    input  logic [RW-1:0]      step,
    output logic [NTHR*RW-1:0] rank_o
);
    // light threads above all heavy ones; shuffle promotes heavy position 'step'
    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            int lv;
            int p;
            int s;
            int h;
            p = int'(hidx[t*RW +: RW]);
            s = int'(step);
            h = int'(hcnt);
            if (light[t])    lv = NTHR - 1 - int'(lidx[t*RW +: RW]);
            else if (p == s) lv = h - 1;
            else if (p < s)  lv = h - 2 - p;
            else             lv = h - 1 - p;
            rank_o[t*RW +: RW] = RW'(lv);
        end
    end
endmodule

// File: rtl/tcp_prio.sv
module tcp_prio
    import tcp_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int QLEN = 1000000,
    parameter int SLEN = 1000,
    parameter int BLPW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NTHR-1:0]      req_v,
    input  logic [NTHR-1:0]      hit_v,
    input  logic [NTHR*BLPW-1:0] blp_i,
    input  logic [FRAC_W-1:0]    thr_i,
    output logic [NTHR*$clog2(NTHR)-1:0] rank_o
);
    localparam int RW  = $clog2(NTHR);
    localparam int HW  = $clog2(NTHR + 1);
    localparam int CW  = $clog2(QLEN + 1);
    localparam int AW  = CW + BLPW;
    localparam int QW  = $clog2(QLEN);
    localparam int SLW = $clog2(SLEN);

    typedef struct packed {
        logic [QW-1:0]      qcnt;
        logic [SLW-1:0]     scnt;
        logic [RW-1:0]      step;
        logic [NTHR-1:0]    light;
        logic [NTHR*RW-1:0] lidx;
        logic [NTHR*RW-1:0] hidx;
        logic [HW-1:0]      hcnt;
    } st_t;

    st_t st_d, st_q;
    logic bnd;

    logic [NTHR*CW-1:0] req_acc;
    logic [NTHR*CW-1:0] hit_acc;
    logic [NTHR*AW-1:0] blp_acc;
    logic [NTHR-1:0]    c_light;
    logic [NTHR*RW-1:0] c_lidx;
    logic [NTHR*RW-1:0] c_hidx;
    logic [HW-1:0]      c_hcnt;

    logic [NTHR-1:0]    light_w;
    logic [HW-1:0]      hcnt_w;
    logic [RW-1:0]      step_w;

    assign bnd     = (st_q.qcnt == QW'(QLEN - 1));
    assign light_w = st_q.light;
    assign hcnt_w  = st_q.hcnt;
    assign step_w  = st_q.step;

    tcp_mon #(.NTHR(NTHR), .CW(CW), .BLPW(BLPW), .AW(AW)) i_mon (
        .clk(clk), .rst_n(rst_n), .clr(bnd),
        .req_v(req_v), .hit_v(hit_v), .blp_i(blp_i),
        .req_acc(req_acc), .hit_acc(hit_acc), .blp_acc(blp_acc)
    );

    tcp_clu #(.NTHR(NTHR), .CW(CW), .AW(AW), .RW(RW), .HW(HW)) i_clu (
        .req_acc(req_acc), .hit_acc(hit_acc), .blp_acc(blp_acc), .thr_i(thr_i),
        .light_o(c_light), .lidx_o(c_lidx), .hidx_o(c_hidx), .hcnt_o(c_hcnt)
    );

    tcp_rank #(.NTHR(NTHR), .RW(RW), .HW(HW)) i_rank (
        .light(light_w), .lidx(st_q.lidx), .hidx(st_q.hidx),
        .hcnt(hcnt_w), .step(step_w), .rank_o(rank_o)
    );

    always_comb begin
        st_d = st_q;
        if (bnd) begin
            st_d.qcnt  = '0;
            st_d.scnt  = '0;
            st_d.step  = '0;
            st_d.light = c_light;
            st_d.lidx  = c_lidx;
            st_d.hidx  = c_hidx;
            st_d.hcnt  = c_hcnt;
        end else begin
            st_d.qcnt = st_q.qcnt + 1'b1;
            if (st_q.scnt == SLW'(SLEN - 1)) begin
                st_d.scnt = '0;
                if (int'(st_q.hcnt) > 1 && int'(st_q.step) + 1 < int'(st_q.hcnt))
                    st_d.step = st_q.step + 1'b1;
                else
                    st_d.step = '0;
            end else begin
                st_d.scnt = st_q.scnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.qcnt  <= '0;
            st_q.scnt  <= '0;
            st_q.step  <= '0;
            st_q.light <= '1;
            st_q.hidx  <= '0;
            st_q.hcnt  <= '0;
            for (int t = 0; t < NTHR; t++) st_q.lidx[t*RW +: RW] <= RW'(t);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tcp_chk.sv
module tcp_chk #(
    parameter int NTHR = 4,
    parameter int RW   = 2,
    parameter int HW   = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NTHR*RW-1:0]   rank,
    input logic [NTHR-1:0]      light,
    input logic [HW-1:0]        hcnt,
    input logic [RW-1:0]        step,
    input logic                 bnd
);
    localparam int NL = 1 << RW;
    logic [NL-1:0] seen;
    logic [NL-1:0] full;

    always_comb begin
        seen = '0;
        full = '0;
        for (int t = 0; t < NTHR; t++) begin
            seen[rank[t*RW +: RW]] = 1'b1;
            full[t] = 1'b1;
        end
    end

    // R9
    rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) seen == full);

    for (genvar t = 0; t < NTHR; t++) begin : g_lvl
        // R4
        light_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
            light[t] |-> ({1'b0, rank[t*RW +: RW]} >= (RW+1)'(hcnt)));
        // R4
        heavy_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !light[t] |-> ({1'b0, rank[t*RW +: RW]} < (RW+1)'(hcnt)));
    end

    // R8
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt > 1) |-> ((RW+1)'(step) < (RW+1)'(hcnt)));
    // R8
    step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt <= 1) |-> (step == '0));
    // R8
    step_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd |=> (step == '0));
    // R2
    split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(light));
endmodule

bind tcp_prio tcp_chk #(.NTHR(NTHR), .RW(RW), .HW(HW)) i_chk (
    .clk(clk), .rst_n(rst_n), .rank(rank_o), .light(light_w),
    .hcnt(hcnt_w), .step(step_w), .bnd(bnd)
);

// File: tb/test_tcp_prio.sv
module test_tcp_prio;
    localparam int CLK_P = 10;
    localparam int NTHR  = 4;
    localparam int QLEN  = 40;
    localparam int SLEN  = 8;
    localparam int BLPW  = 3;
    localparam int RW    = 2;

    typedef int arr_t [NTHR];

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NTHR-1:0]      req_v = '0;
    logic [NTHR-1:0]      hit_v = '0;
    logic [NTHR*BLPW-1:0] blp_i = '0;
    logic [7:0]           thr_i = '0;
    logic [NTHR*RW-1:0]   rank_o;

    tcp_prio #(.NTHR(NTHR), .QLEN(QLEN), .SLEN(SLEN), .BLPW(BLPW)) i_tcp_prio (
        .clk(clk), .rst_n(rst_n), .req_v(req_v), .hit_v(hit_v),
        .blp_i(blp_i), .thr_i(thr_i), .rank_o(rank_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    // scoreboard queues
    logic [NTHR*RW-1:0] exp_q [$];
    string              tag_q [$];
    event               smp_ev;

    // reference model state
    int cnt_r [NTHR];
    int cnt_h [NTHR];
    int cnt_b [NTHR];
    bit lt    [NTHR];
    int li    [NTHR];
    int hi    [NTHR];
    int hh;
    int thr_v;

    task automatic push_exp(input logic [NTHR*RW-1:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        -> smp_ev;
    endtask

    // monitor: pops expected vectors and compares against the port
    initial begin
        forever begin
            @(smp_ev);
            while (exp_q.size() > 0) begin
                logic [NTHR*RW-1:0] e;
                string tg;
                bit [NTHR-1:0] seen;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                nchk++;
                if (rank_o !== e) begin
                    nerr++;
                    $display("FAIL %s: rank_o=%h expected %h", tg, rank_o, e);
                end
                seen = '0;
                for (int t = 0; t < NTHR; t++) seen[rank_o[t*RW +: RW]] = 1'b1;
                nchk++;
                if (seen != '1) begin
                    nerr++;
                    $display("FAIL R9 permutation: rank_o=%h levels seen %b expected 1111", rank_o, seen);
                end
            end
        end
    end

    // R3 R5 R6: cluster decision from tallied counts
    task automatic decide();
        longint total;
        total = 0;
        for (int t = 0; t < NTHR; t++) total += cnt_r[t];
        hh = 0;
        for (int t = 0; t < NTHR; t++) begin
            longint pre;
            pre = 0;
            for (int j = 0; j < NTHR; j++)
                if (cnt_r[j] < cnt_r[t] || (cnt_r[j] == cnt_r[t] && j <= t)) pre += cnt_r[j];
            lt[t] = (pre * 256) <= (longint'(thr_v) * total);
            if (!lt[t]) hh++;
        end
        for (int t = 0; t < NTHR; t++) begin
            int nl;
            int np;
            int nc_t;
            int br;
            int hr;
            nl = 0;
            np = 0;
            br = 0;
            hr = 0;
            for (int j = 0; j < NTHR; j++) begin
                if (cnt_b[j] < cnt_b[t]) br++;
                if (cnt_h[j] < cnt_h[t]) hr++;
            end
            nc_t = br - hr;
            for (int j = 0; j < NTHR; j++) begin
                int bj;
                int hj;
                int nc_j;
                bj = 0;
                hj = 0;
                for (int k = 0; k < NTHR; k++) begin
                    if (cnt_b[k] < cnt_b[j]) bj++;
                    if (cnt_h[k] < cnt_h[j]) hj++;
                end
                nc_j = bj - hj;
                if (j != t && lt[j] && (cnt_r[j] < cnt_r[t] || (cnt_r[j] == cnt_r[t] && j < t))) nl++;
                if (j != t && !lt[j] && (nc_j > nc_t || (nc_j == nc_t && j < t))) np++;
            end
            li[t] = nl;
            hi[t] = np;
        end
    endtask

    // R4 R5 R7 R10: expected level vector at a shuffle step
    function automatic logic [NTHR*RW-1:0] exp_vec(input int s);
        logic [NTHR*RW-1:0] v;
        for (int t = 0; t < NTHR; t++) begin
            int lv;
            if (lt[t])          lv = NTHR - 1 - li[t];
            else if (hi[t] == s) lv = hh - 1;
            else if (hi[t] < s)  lv = hh - 2 - hi[t];
            else                 lv = hh - 1 - hi[t];
            v[t*RW +: RW] = RW'(lv);
        end
        return v;
    endfunction

    // one quantum of traffic: thread t requests when c % rq[t] == 0 (0 = never),
    // hits when also c % hp[t] == 0 (0 = never), reports bl[t] busy banks
    task automatic run_q(input arr_t rq, input arr_t hp, input arr_t bl, input int thr);
        thr_i = 8'(thr);
        thr_v = thr;
        for (int t = 0; t < NTHR; t++) begin
            cnt_r[t] = 0;
            cnt_h[t] = 0;
            cnt_b[t] = 0;
        end
        for (int c = 0; c < QLEN; c++) begin
            for (int t = 0; t < NTHR; t++) begin
                bit r;
                bit h;
                r = (rq[t] != 0) && (c % rq[t] == 0);
                h = r && (hp[t] != 0) && (c % hp[t] == 0);
                req_v[t] = r;
                hit_v[t] = h;
                blp_i[t*BLPW +: BLPW] = r ? BLPW'(bl[t]) : '0;
                if (r) begin
                    cnt_r[t]++;
                    cnt_b[t] += bl[t];
                end
                if (h) cnt_h[t]++;
            end
            @(posedge clk);
            @(negedge clk);
            if (c == QLEN - 1) begin
                decide();
                push_exp(exp_vec(0), "R2 R3 R4 R5 R6 R7 quantum decision");
            end else if ((c + 1) % SLEN == 0) begin
                int s;
                s = (hh > 1) ? ((c + 1) / SLEN) % hh : 0;
                push_exp(exp_vec(s), "R7 R8 shuffle step, R2 split held");
            end
        end
    endtask

    bit done = 1'b0;

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, all light, level = NTHR-1-ID
        for (int t = 0; t < NTHR; t++) begin
            lt[t] = 1'b1;
            li[t] = t;
            hi[t] = 0;
        end
        hh = 0;
        push_exp(exp_vec(0), "R1 reset levels");
        // Q1: graded intensity, half threshold -> one heavy thread
        run_q('{1, 2, 4, 0}, '{0, 0, 0, 0}, '{1, 1, 1, 0}, 128);
        // Q2: two heavy threads with opposite niceness (R6)
        run_q('{1, 1, 8, 0}, '{1, 0, 1, 0}, '{1, 4, 2, 0}, 64);
        // Q3: equal counts, threshold just below the full total (R3 tie by ID)
        run_q('{2, 2, 2, 2}, '{0, 0, 0, 0}, '{1, 1, 1, 1}, 255);
        // Q4: idle quantum, zero total makes all threads light
        run_q('{0, 0, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 0);
        // Q5: zero threshold -> all four heavy, uneven shuffle
        run_q('{1, 2, 4, 1}, '{1, 0, 1, 2}, '{1, 4, 2, 3}, 0);
        // Q6: idle; watches the four-way shuffle wrap (R8) then returns to all light
        run_q('{0, 0, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 0}, 128);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule